// File: doc/BRIEF.md
# Three-lane pixel frame serializer

This block turns one 27-bit pixel word per pixel period into three serial bit streams. It runs on a bit clock at ten times the pixel rate, and it receives a one-cycle pixel-rate enable that marks each pixel boundary. On each marked edge the block captures the word and adds two reserved bits, both zero, and an odd-parity bit. This gives a 30-bit frame. The frame is cut into three 10-bit slices, and each slice leaves on its own lane, most significant bit first. All three lanes move in lockstep.

A forwarded clock output runs at the pixel rate and lines up with frame boundaries. It is high for the first half of each frame and low for the second half. The receiver uses it to find frame edges and to recover the pixel clock.

A two-bit mode select gates the whole block. Only the three-lane code enables it. Any other code forces every output low, and sending resumes only at the next pixel boundary after the code returns.

Top module: `pixel_lane_serializer`

## Requirements
- R1: The block is enabled only when modeSel is 2'b10 (modeSel[1]=1, modeSel[0]=0). While modeSel holds any other code, all laneOut bits and fwdClk are low from the first bit-clock edge that samples that code.
- R2: The frame is {pixData[26:0], 0, 0, P}. P is odd parity over the payload: it is 1 when pixData has an even number of ones. These three bits are the last three bits sent on laneOut[2].
- R3: laneOut[0] sends pixData[26:17], laneOut[1] sends pixData[16:7], and laneOut[2] sends pixData[6:0] followed by the two reserved zeros and P. Every lane sends most significant bit first.
- R4: A frame starts on the rising bit-clock edge that samples pixEn high while the mode is valid. The first bit appears on all lanes from that edge, and each bit lasts one bit-clock period. pixData is captured only on that edge, so later changes do not affect the frame being sent.
- R5: All three lanes start every frame on the same edge and change bits on the same edges.
- R6: fwdClk rises on the frame-start edge, stays high for bit periods 0 to 4, and is low for bit periods 5 to 9.
- R7: When pixEn pulses every ten bit-clock cycles, consecutive frames follow with no idle bit between them.
- R8: If no pixEn pulse arrives after the tenth bit of a frame, all lanes and fwdClk go low and stay low until the next frame starts.
- R9: After modeSel returns to 2'b10, the outputs stay low until the next pixEn pulse, and that pulse starts a complete, correct frame.
- R10: The active-low asynchronous reset rstN drives all lanes and fwdClk low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, ten times the pixel rate |
| rstN | input | 1 | Asynchronous reset, active low |
| pixEn | input | 1 | One-cycle pulse marking each pixel boundary |
| modeSel | input | 2 | Lane mode code; 2'b10 enables three-lane operation |
| pixData | input | 27 | Pixel payload word |
| laneOut | output | 3 | Serial data lanes; bit k is lane k |
| fwdClk | output | 1 | Forwarded pixel-rate clock, aligned to frames |

## Verification
All output changes are registered. The first bit of a frame and the rise of fwdClk appear one bit-clock edge after the edge that samples pixEn. The n-th bit of the frame is present after n further edges. Blanking takes effect on the first edge that samples an invalid mode code. The bench drives inputs and samples outputs on falling edges, so every sample falls mid-period after the edge that is due. Each frame task reads all ten bit periods at these points and compares them with a frame built from the requirements.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;

  // Mode code that enables three-lane operation (bit1 high, bit0 low).
  localparam logic [1:0] THREE_LANE_CODE = 2'b10;

  // Strobes from the control to the datapath; exactly one is set per cycle.
  typedef struct packed {
    logic load;   // capture a new frame into the lane shifters
    logic shift;  // advance every lane by one bit
    logic clear;  // drive every lane low
  } laneStrobe_t;

endpackage

// File: rtl/lane_ser_ctrl.sv
module lane_ser_ctrl
  import lane_ser_pkg::*;
#(
  parameter int SLICE_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixEn,
  input  logic [1:0]  modeSel,
  output laneStrobe_t strobe,
  output logic        fwdClk
);

  localparam int IDX_W = $clog2(SLICE_W);
  localparam int LAST  = SLICE_W - 1;
  localparam int HALF  = SLICE_W / 2;

  logic             busy;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             modeOk;
  logic             atEnd;

  assign modeOk  = (modeSel == THREE_LANE_CODE);
  assign atEnd   = (bitIdx == IDX_W'(LAST));
  assign nextIdx = bitIdx + 1'b1;

  always_comb begin
    strobe.load  = modeOk && pixEn;
    strobe.shift = modeOk && !pixEn && busy && !atEnd;
    strobe.clear = !strobe.load && !strobe.shift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
      fwdClk <= 1'b0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      bitIdx <= '0;
      fwdClk <= 1'b1;
    end else if (strobe.shift) begin
      bitIdx <= nextIdx;
      fwdClk <= (nextIdx < IDX_W'(HALF));
    end else begin
      busy   <= 1'b0;
      bitIdx <= '0;
      fwdClk <= 1'b0;
    end
  end

endmodule

// File: rtl/lane_ser_dp.sv
module lane_ser_dp
  import lane_ser_pkg::*;
#(
  parameter int PAYLOAD_W = 27,
  parameter int SLICE_W   = 10,
  parameter int LANES     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  laneStrobe_t          strobe,
  input  logic [PAYLOAD_W-1:0] pixData,
  output logic [LANES-1:0]     laneOut
);

  localparam int FRAME_W = LANES * SLICE_W;
  localparam int RSV_W   = FRAME_W - PAYLOAD_W - 1;

  logic               oddPar;
  logic [FRAME_W-1:0] frame;

  // Odd parity: the parity bit makes the total count of ones odd.
  assign oddPar = ~(^pixData);
  assign frame  = {pixData, {RSV_W{1'b0}}, oddPar};

  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [SLICE_W-1:0] shiftReg;
    logic [SLICE_W-1:0] slice;

    assign slice = frame[FRAME_W-1-k*SLICE_W -: SLICE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else if (strobe.load) begin
        shiftReg <= slice;
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[SLICE_W-2:0], 1'b0};
      end else begin
        shiftReg <= '0;
      end
    end

    assign laneOut[k] = shiftReg[SLICE_W-1];
  end

endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int PAYLOAD_W = 27,
  parameter int SLICE_W   = 10,
  parameter int LANES     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pixEn,
  input  logic [1:0]           modeSel,
  input  logic [PAYLOAD_W-1:0] pixData,
  output logic [LANES-1:0]     laneOut,
  output logic                 fwdClk
);

  laneStrobe_t strobe;

  lane_ser_ctrl #(
    .SLICE_W(SLICE_W)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pixEn  (pixEn),
    .modeSel(modeSel),
    .strobe (strobe),
    .fwdClk (fwdClk)
  );

  lane_ser_dp #(
    .PAYLOAD_W(PAYLOAD_W),
    .SLICE_W  (SLICE_W),
    .LANES    (LANES)
  ) dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pixData(pixData),
    .laneOut(laneOut)
  );

endmodule

// File: rtl/lane_ser_checker.sv
module lane_ser_checker
  import lane_ser_pkg::*;
#(
  parameter int SLICE_W = 10,
  parameter int LANES   = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixEn,
  input logic [1:0]       modeSel,
  input logic             pixMsb,
  input logic [LANES-1:0] laneOut,
  input logic             fwdClk
);

  localparam int SAT   = SLICE_W + 5;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam int HALF  = SLICE_W / 2;

  logic             startSeen;
  logic [CNT_W-1:0] sinceLoad;

  assign startSeen = pixEn && (modeSel == THREE_LANE_CODE);

  // Output bit periods elapsed since the last frame start, from the ports only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         sinceLoad <= CNT_W'(SAT);
    else if (startSeen)                sinceLoad <= '0;
    else if (sinceLoad != CNT_W'(SAT)) sinceLoad <= sinceLoad + 1'b1;
  end

  a_r1_blank_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != THREE_LANE_CODE) |=> (laneOut == '0 && !fwdClk));

  a_r4_first_bit_msb: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (laneOut[0] == $past(pixMsb)));

  a_r6_clk_rises_at_start: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> fwdClk);

  a_r6_clk_low_half: assert property (@(posedge clk) disable iff (!rstN)
    (sinceLoad >= CNT_W'(HALF) && sinceLoad < CNT_W'(SLICE_W)) |-> !fwdClk);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (sinceLoad == CNT_W'(SLICE_W-3) || sinceLoad == CNT_W'(SLICE_W-2))
      |-> !laneOut[LANES-1]);

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (sinceLoad >= CNT_W'(SLICE_W)) |-> (laneOut == '0 && !fwdClk));

endmodule

bind pixel_lane_serializer lane_ser_checker #(
  .SLICE_W(SLICE_W),
  .LANES  (LANES)
) chk (
  .clk    (clk),
  .rstN   (rstN),
  .pixEn  (pixEn),
  .modeSel(modeSel),
  .pixMsb (pixData[PAYLOAD_W-1]),
  .laneOut(laneOut),
  .fwdClk (fwdClk)
);

// File: tb/pixel_lane_serializer_test.sv
module pixel_lane_serializer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0;
  logic [1:0]  modeSel = 2'b10;
  logic [26:0] pixData = '0;
  logic [2:0]  laneOut;
  logic        fwdClk;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_lane_serializer uut (
    .clk    (clk),
    .rstN   (rstN),
    .pixEn  (pixEn),
    .modeSel(modeSel),
    .pixData(pixData),
    .laneOut(laneOut),
    .fwdClk (fwdClk)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [29:0] buildFrame(input logic [26:0] d);
    int ones = 0;
    for (int i = 0; i < 27; i++) ones += d[i];
    return {d, 2'b00, (ones % 2 == 0)};
  endfunction

  // Entered and left on a falling edge. Sends one frame and checks all bits.
  task automatic sendFrame(input logic [26:0] d, input bit scramble, output bit ok);
    logic [9:0]  got0, got1, got2, gotClk;
    logic [29:0] ef;
    ef = buildFrame(d);
    pixEn = 1'b1;
    pixData = d;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j == 0) begin
        pixEn = 1'b0;
        if (scramble) pixData = ~d;
      end
      got0[9-j]   = laneOut[0];
      got1[9-j]   = laneOut[1];
      got2[9-j]   = laneOut[2];
      gotClk[9-j] = fwdClk;
    end
    ok = (got0 === ef[29:20]) && (got1 === ef[19:10]) &&
         (got2 === ef[9:0]) && (gotClk === 10'b1111100000);
    check("R3 lane0", 32'(got0), 32'(ef[29:20]));
    check("R3 lane1", 32'(got1), 32'(ef[19:10]));
    check("R2 lane2 with reserved and parity", 32'(got2), 32'(ef[9:0]));
    check("R6 fwdClk", 32'(gotClk), 32'(10'b1111100000));
  endtask

  task automatic expectQuiet(input string tag, input int cycles);
    bit quiet = 1;
    logic [3:0] seen = '0;
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      if (laneOut !== 3'b000 || fwdClk !== 1'b0) begin
        quiet = 0;
        seen = {fwdClk, laneOut};
      end
    end
    check(tag, 32'(seen), 32'(0));
  endtask

  task automatic testReset();
    pixEn = 1'b1;
    pixData = 27'h7FFFFFF;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {28'd0, fwdClk, laneOut}, 32'd0);
    pixEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testBadModes();
    logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b11};
    foreach (codes[c]) begin
      modeSel = codes[c];
      pixEn = 1'b1;
      pixData = 27'h7FFFFFF;
      @(negedge clk);
      pixEn = 1'b0;
      expectQuiet("R1 invalid mode keeps outputs low", 12);
    end
    modeSel = 2'b10;
  endtask

  task automatic testPatterns();
    bit ok;
    sendFrame(27'h0000000, 0, ok);
    sendFrame(27'h7FFFFFF, 0, ok);
    sendFrame(27'h2AAAAAA, 0, ok);
    sendFrame(27'h5555555, 0, ok);
    sendFrame(27'h4B3C2D1, 0, ok);
    for (int i = 0; i < 27; i += 3) begin
      sendFrame(27'(1) << i, 0, ok);
      check("R5 lanes in lockstep", 32'(ok), 32'(1));
    end
  endtask

  task automatic testBackToBack();
    bit ok, all = 1;
    sendFrame(27'h1234567, 0, ok); all &= ok;
    sendFrame(27'h6543210, 0, ok); all &= ok;
    sendFrame(27'h0F0F0F0, 0, ok); all &= ok;
    check("R7 back-to-back frames", 32'(all), 32'(1));
    expectQuiet("R8 idle after last frame", 6);
  endtask

  task automatic testCaptureOnce();
    bit ok;
    sendFrame(27'h3C5A961, 1, ok);
    check("R4 payload captured at start only", 32'(ok), 32'(1));
  endtask

  task automatic testModeDrop();
    bit ok;
    pixEn = 1'b1;
    pixData = 27'h7FFFFFF;
    @(negedge clk);
    pixEn = 1'b0;
    repeat (2) @(negedge clk);
    modeSel = 2'b00;
    @(negedge clk);
    check("R1 blank on first edge after mode drop", {28'd0, fwdClk, laneOut}, 32'd0);
    expectQuiet("R1 stays blank", 5);
    modeSel = 2'b10;
    expectQuiet("R9 silent until next pixEn", 6);
    sendFrame(27'h2468ACE, 0, ok);
    check("R9 first frame after restore", 32'(ok), 32'(1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testBadModes();
    testPatterns();
    testBackToBack();
    testCaptureOnce();
    testModeDrop();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule